// File: doc/BRIEF.md
# Wide Register Indirect Access Bridge

This block gives a host that can only issue 32-bit word accesses a way to read and write a bank of 64-bit registers. It does this through a small host-side window. The host stages a 64-bit value as two 32-bit halves. It then writes a command word that holds the transfer direction and the target register address. The bridge turns that command into one request on a valid/ready internal register port and waits for the response. For a read, it returns the result into the two halves.

The host polls a status word. The status word shows whether a transfer is still in flight and whether any error has been seen since it was last cleared. The error can come from an error response on the internal port or from a command issued while the bridge was busy. A write of any value to a dedicated clear word drops the error flag and abandons any transfer in flight.

Top module: `wide_reg_bridge`

## Requirements
- R1: While `rst_n` is low and right after it rises, `req_valid` is 0 and every readable offset returns 0.
- R2: A host write to byte offset 0x00 loads the upper half (bits 63:32) and a write to 0x04 loads the lower half (bits 31:0). Both read back at the same offsets. Host bits 31:24 of offset 0x00 carry the most significant byte of the 64-bit value.
- R3: A command write (offset 0x08) with bit 31 set, issued while idle, raises `req_valid` on the next cycle. It drives `req_write`=1, `req_addr` = command bits [REG_AW-1:0] and `req_wdata` = {upper, lower}.
- R4: A command write with bit 31 clear raises a request with `req_write`=0. An error-free response loads `rsp_rdata[63:32]` into offset 0x00 and `rsp_rdata[31:0]` into offset 0x04, visible from the cycle after `rsp_valid`.
- R5: `req_valid` and the request fields stay stable until `req_ready` is seen. Only one request is outstanding at a time. A response counts only in a cycle after the request handshake.
- R6: Status (offset 0x1C) bit 0 is a busy flag. It is 1 from the cycle after the command write until the cycle after the response is accepted.
- R7: A response with `rsp_err`=1 sets status bit 31 and leaves both data halves unchanged.
- R8: A command write while busy starts no new request and does not change the pending one. It sets status bit 31.
- R9: Writes to offsets 0x00 and 0x04 while busy are ignored.
- R10: A write of any value to offset 0x18 clears status bit 31, returns the bridge to idle (busy 0, `req_valid` 0) and leaves the data halves as they were. A response that arrives after such an abort is ignored.
- R11: Offsets 0x08, 0x0C, 0x10, 0x14 and 0x18 read as 0. Status bits 30:1 read as 0. Writes to 0x0C, 0x10 and 0x14 change nothing.
- R12: Command bits 30:REG_AW do not affect the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | HOST_AW | Host byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from `host_addr` while `host_sel` is high |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_write | output | 1 | 1 = internal write, 0 = internal read |
| req_addr | output | REG_AW | Internal register address |
| req_wdata | output | 64 | Internal write data |
| rsp_valid | input | 1 | Internal response valid |
| rsp_rdata | input | 64 | Internal read data |
| rsp_err | input | 1 | Internal response error |

## Verification
The hardest case to reach from the ports is a host action that lands inside the window between the command write and the response: a second command, a data-half write, or a clear that abandons the transfer. The bench reaches it by acting as the internal responder itself. It holds `req_ready` and `rsp_valid` back for a chosen number of cycles and issues host writes in that gap. After an abort it drives a stale response to show that the response is dropped. The address sweep varies the ready and response delays with the register index, so that every stall length from zero to two cycles is covered.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } wrb_state_e;

    // byte offsets of the writable words, index order: upper, lower, command, clear
    localparam int unsigned N_WR = 4;
    localparam logic [N_WR-1:0][7:0] WR_OFS = {8'h18, 8'h08, 8'h04, 8'h00};
    localparam int unsigned W_HI  = 0;
    localparam int unsigned W_LO  = 1;
    localparam int unsigned W_CMD = 2;
    localparam int unsigned W_CLR = 3;

    localparam logic [7:0] OFS_STATUS = 8'h1C;
    localparam int unsigned ST_ERR_BIT  = 31;
    localparam int unsigned ST_BUSY_BIT = 0;
    localparam int unsigned CMD_DIR_BIT = 31;

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    output logic [N_WR-1:0]    wr_strobe
);

    logic [HOST_AW-1:0] word_addr;
    logic               unused_lsb;

    assign word_addr  = {host_addr[HOST_AW-1:2], 2'b00};
    assign unused_lsb = ^host_addr[1:0];

    for (genvar g = 0; g < N_WR; g++) begin : g_strobe
        localparam logic [HOST_AW-1:0] OFS = HOST_AW'(WR_OFS[g]);
        assign wr_strobe[g] = host_sel && host_wr && (word_addr == OFS);
    end

endmodule

// File: rtl/wrb_engine.sv
module wrb_engine
    import wrb_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WR-1:0]   wr_strobe,
    input  logic [31:0]       wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_rdata,
    input  logic              rsp_err,
    output logic              req_valid,
    output logic              req_write,
    output logic [REG_AW-1:0] req_addr,
    output logic [63:0]       req_wdata,
    output logic [31:0]       upper,
    output logic [31:0]       lower,
    output logic              busy,
    output logic              err
);

    typedef struct packed {
        wrb_state_e        st;
        logic [31:0]       hi;
        logic [31:0]       lo;
        logic [REG_AW-1:0] addr;
        logic              wr;
        logic              err;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (wr_strobe[W_HI]) eng_d.hi = wdata;
                if (wr_strobe[W_LO]) eng_d.lo = wdata;
                if (wr_strobe[W_CMD]) begin
                    eng_d.st   = ST_REQ;
                    eng_d.addr = wdata[REG_AW-1:0];
                    eng_d.wr   = wdata[CMD_DIR_BIT];
                end
            end
            ST_REQ: begin
                if (req_ready) eng_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    eng_d.st = ST_IDLE;
                    if (rsp_err) begin
                        eng_d.err = 1'b1;
                    end else if (!eng_q.wr) begin
                        eng_d.hi = rsp_rdata[63:32];
                        eng_d.lo = rsp_rdata[31:0];
                    end
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        if (wr_strobe[W_CMD] && (eng_q.st != ST_IDLE)) eng_d.err = 1'b1;
        if (wr_strobe[W_CLR]) begin
            eng_d.st  = ST_IDLE;
            eng_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign req_valid = (eng_q.st == ST_REQ);
    assign req_write = eng_q.wr;
    assign req_addr  = eng_q.addr;
    assign req_wdata = {eng_q.hi, eng_q.lo};
    assign upper     = eng_q.hi;
    assign lower     = eng_q.lo;
    assign busy      = (eng_q.st != ST_IDLE);
    assign err       = eng_q.err;

endmodule

// File: rtl/wrb_rdmux.sv
module wrb_rdmux
    import wrb_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic               host_sel,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        upper,
    input  logic [31:0]        lower,
    input  logic               busy,
    input  logic               err,
    output logic [31:0]        host_rdata
);

    localparam logic [HOST_AW-1:0] A_HI = HOST_AW'(WR_OFS[W_HI]);
    localparam logic [HOST_AW-1:0] A_LO = HOST_AW'(WR_OFS[W_LO]);
    localparam logic [HOST_AW-1:0] A_ST = HOST_AW'(OFS_STATUS);

    logic [HOST_AW-1:0] word_addr;
    logic [31:0]        status;

    assign word_addr = {host_addr[HOST_AW-1:2], 2'b00};

    always_comb begin
        status              = '0;
        status[ST_ERR_BIT]  = err;
        status[ST_BUSY_BIT] = busy;
    end

    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            if (word_addr == A_HI)      host_rdata = upper;
            else if (word_addr == A_LO) host_rdata = lower;
            else if (word_addr == A_ST) host_rdata = status;
        end
    end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int HOST_AW = 5,
    parameter int REG_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               req_valid,
    input  logic               req_ready,
    output logic               req_write,
    output logic [REG_AW-1:0]  req_addr,
    output logic [63:0]        req_wdata,
    input  logic               rsp_valid,
    input  logic [63:0]        rsp_rdata,
    input  logic               rsp_err
);

    logic [N_WR-1:0] wr_strobe;
    logic [31:0]     upper;
    logic [31:0]     lower;
    logic            busy;
    logic            err;

    wrb_decode #(.HOST_AW(HOST_AW)) i_decode (
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .wr_strobe (wr_strobe)
    );

    wrb_engine #(.REG_AW(REG_AW)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wdata     (host_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .upper     (upper),
        .lower     (lower),
        .busy      (busy),
        .err       (err)
    );

    wrb_rdmux #(.HOST_AW(HOST_AW)) i_rdmux (
        .host_sel   (host_sel),
        .host_addr  (host_addr),
        .upper      (upper),
        .lower      (lower),
        .busy       (busy),
        .err        (err),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_WR-1:0]   wr_strobe,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [REG_AW-1:0] req_addr,
    input logic [63:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              busy,
    input logic              err
);

    // R3: an idle command launches a request next cycle
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe[W_CMD] && !busy && !wr_strobe[W_CLR] |=> req_valid);

    // R5: request held steady until accepted
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !wr_strobe[W_CLR] |=>
            req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

    // R6: a pending request always shows as busy
    a_r6_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    // R7: error response in the wait phase raises the error flag
    a_r7_rsp_err: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err && busy && !req_valid && !wr_strobe[W_CLR] |=> err);

    // R8: command while busy raises the error flag
    a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe[W_CMD] && busy && !wr_strobe[W_CLR] |=> err);

    // R8: error flag holds until the clear word is written
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err && !wr_strobe[W_CLR] |=> err);

    // R10: clear word drops the flag and returns to idle
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe[W_CLR] |=> !err && !busy && !req_valid);

    // R2: at most one window word is written per cycle
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));

endmodule

bind wide_reg_bridge wrb_checker #(.REG_AW(REG_AW)) i_wrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .busy      (busy),
    .err       (err)
);

// File: tb/test_wide_reg_bridge.sv
`timescale 1ns/1ps
module test_wide_reg_bridge;

    localparam int HOST_AW = 5;
    localparam int REG_AW  = 8;
    localparam int NREG    = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_sel = 1'b0;
    logic               host_wr = 1'b0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [31:0]        host_wdata = '0;
    logic [31:0]        host_rdata;
    logic               req_valid;
    logic               req_ready = 1'b0;
    logic               req_write;
    logic [REG_AW-1:0]  req_addr;
    logic [63:0]        req_wdata;
    logic               rsp_valid = 1'b0;
    logic [63:0]        rsp_rdata = '0;
    logic               rsp_err = 1'b0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [63:0] bank [NREG];

    always #4 clk = ~clk;

    wide_reg_bridge #(.HOST_AW(HOST_AW), .REG_AW(REG_AW)) i_wide_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a[HOST_AW-1:0]; host_wdata = d;
        @(posedge clk);
        #1 host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a[HOST_AW-1:0];
        #1 d = host_rdata;
        host_sel = 1'b0;
    endtask

    function automatic logic [63:0] pattern(input int a);
        return {32'h0101_0101 * 32'(a + 1) ^ 32'hA500_005A, 32'h1000_0003 * 32'(a + 7)};
    endfunction

    // launch a command and play the internal responder
    task automatic do_cmd(input logic [31:0] cmd, input int rdly, input int sdly,
                          input logic exp_wr, input logic [REG_AW-1:0] exp_addr,
                          input logic [63:0] exp_wdata, input logic [63:0] rdata,
                          input logic rerr);
        logic [31:0] st;
        host_write(8'h08, cmd);
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            check("R5 valid held while not ready", {63'd0, req_valid}, 64'd1);
        end
        @(negedge clk);
        check("R3/R4 req_valid", {63'd0, req_valid}, 64'd1);
        check("R3/R4 req_write", {63'd0, req_write}, {63'd0, exp_wr});
        check("R12 req_addr", 64'(req_addr), 64'(exp_addr));
        if (exp_wr) check("R3 req_wdata", req_wdata, exp_wdata);
        req_ready = 1'b1;
        @(posedge clk);
        #1 req_ready = 1'b0;
        for (int i = 0; i < sdly; i++) begin
            host_read(8'h1C, st);
            check("R6 busy while waiting", 64'(st), 64'h1);
            check("R5 single request", {63'd0, req_valid}, 64'd0);
        end
        @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = rdata; rsp_err = rerr;
        @(posedge clk);
        #1 rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] rd2;
        logic [63:0] v;
        logic [31:0] cmd;

        // R1 during and after reset
        repeat (3) @(negedge clk);
        check("R1 req_valid in reset", {63'd0, req_valid}, 64'd0);
        rst_n = 1'b1;
        host_read(8'h00, rd); check("R1 upper", 64'(rd), 64'd0);
        host_read(8'h04, rd); check("R1 lower", 64'(rd), 64'd0);
        host_read(8'h1C, rd); check("R1 status", 64'(rd), 64'd0);
        check("R1 req_valid", {63'd0, req_valid}, 64'd0);

        // R2 byte order and R3 writes across the register sweep
        for (int a = 0; a < NREG; a++) begin
            v = pattern(a);
            bank[a] = v;
            host_write(8'h00, v[63:32]);
            host_write(8'h04, v[31:0]);
            host_read(8'h00, rd); check("R2 upper readback", 64'(rd), 64'(v[63:32]));
            host_read(8'h04, rd); check("R2 lower readback", 64'(rd), 64'(v[31:0]));
            cmd = 32'h8000_0000 | 32'(a);
            do_cmd(cmd, a % 3, a % 2, 1'b1, REG_AW'(a), v, 64'd0, 1'b0);
            host_read(8'h1C, rd); check("R6 idle after write", 64'(rd), 64'd0);
        end

        // R2 most significant byte position
        host_write(8'h00, 32'h1122_3344);
        host_write(8'h04, 32'h5566_7788);
        do_cmd(32'h8000_0005, 0, 0, 1'b1, 8'h05, 64'h1122_3344_5566_7788, 64'd0, 1'b0);
        check("R2 msb byte on req_wdata", 64'(req_wdata[63:56]), 64'h11);

        // R4 reads with junk in command bits 30:REG_AW (R12)
        for (int a = 0; a < NREG; a++) begin
            cmd = {1'b0, 23'h5A5A5 ^ 23'(a * 9), 8'(a)};
            do_cmd(cmd, (a + 1) % 3, (a + 2) % 3, 1'b0, REG_AW'(a), 64'd0, bank[a], 1'b0);
            host_read(8'h00, rd);  check("R4 upper from response", 64'(rd), 64'(bank[a][63:32]));
            host_read(8'h04, rd2); check("R4 lower from response", 64'(rd2), 64'(bank[a][31:0]));
            host_read(8'h1C, rd);  check("R6 idle after read", 64'(rd), 64'd0);
        end

        // R7 error response keeps data
        do_cmd(32'h0000_0003, 1, 1, 1'b0, 8'h03, 64'd0, 64'hDEAD_BEEF_CAFE_F00D, 1'b1);
        host_read(8'h1C, rd); check("R7 error flag", 64'(rd), 64'h8000_0000);
        host_read(8'h00, rd); check("R7 upper kept", 64'(rd), 64'(bank[15][63:32]));
        host_read(8'h04, rd); check("R7 lower kept", 64'(rd), 64'(bank[15][31:0]));
        host_write(8'h18, 32'h0);
        host_read(8'h1C, rd); check("R10 clear error", 64'(rd), 64'd0);

        // R8 and R9: second command and data writes while busy
        host_write(8'h08, 32'h0000_0002);
        host_write(8'h08, 32'h8000_0009);
        host_write(8'h00, 32'hFFFF_0000);
        host_write(8'h04, 32'h0000_FFFF);
        @(negedge clk);
        check("R8 pending addr kept", 64'(req_addr), 64'h02);
        check("R8 pending dir kept", {63'd0, req_write}, 64'd0);
        host_read(8'h1C, rd); check("R8 error and busy", 64'(rd), 64'h8000_0001);
        @(negedge clk);
        req_ready = 1'b1;
        @(posedge clk); #1 req_ready = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = 64'h0; rsp_err = 1'b1;
        @(posedge clk); #1 rsp_valid = 1'b0; rsp_err = 1'b0;
        @(negedge clk);
        check("R8 no second request", {63'd0, req_valid}, 64'd0);
        host_read(8'h00, rd); check("R9 upper ignored while busy", 64'(rd), 64'(bank[15][63:32]));
        host_read(8'h04, rd); check("R9 lower ignored while busy", 64'(rd), 64'(bank[15][31:0]));
        host_read(8'h1C, rd); check("R8 flag sticks when idle", 64'(rd), 64'h8000_0000);
        host_write(8'h18, 32'hFFFF_FFFF);

        // R10 abort during request, then during wait with a stale response
        host_write(8'h08, 32'h0000_0004);
        host_write(8'h18, 32'h1234_5678);
        @(negedge clk);
        check("R10 request dropped", {63'd0, req_valid}, 64'd0);
        host_read(8'h1C, rd); check("R10 idle after abort", 64'(rd), 64'd0);
        host_write(8'h08, 32'h0000_0006);
        @(negedge clk);
        req_ready = 1'b1;
        @(posedge clk); #1 req_ready = 1'b0;
        host_write(8'h18, 32'h0);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = 64'hBAD0_BAD0_BAD0_BAD0;
        @(posedge clk); #1 rsp_valid = 1'b0;
        host_read(8'h00, rd); check("R10 late response ignored upper", 64'(rd), 64'(bank[15][63:32]));
        host_read(8'h04, rd); check("R10 late response ignored lower", 64'(rd), 64'(bank[15][31:0]));
        host_read(8'h1C, rd); check("R10 still idle", 64'(rd), 64'd0);

        // R11 unmapped offsets
        host_write(8'h0C, 32'hAAAA_AAAA);
        host_write(8'h10, 32'h5555_5555);
        host_write(8'h14, 32'h8000_0001);
        host_read(8'h1C, rd); check("R11 no launch from unmapped write", 64'(rd), 64'd0);
        host_read(8'h00, rd); check("R11 upper untouched", 64'(rd), 64'(bank[15][63:32]));
        foreach (WRO[i]) begin
            host_read(WRO[i], rd); check("R11 reads zero", 64'(rd), 64'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [7:0] WRO [5] = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};

endmodule